// File: doc/BRIEF.md
# Silicon Strip Cluster Finder with Road Window Matching

This block takes silicon strip hits from several detector inputs at once. Each hit carries a strip address and a raw pulse height. A per-strip table supplies a dead-strip flag, a pedestal and a gain factor. Dead strips are discarded. The pedestal is subtracted and the gain is applied to every other hit. Each input has its own clustering stage. That stage merges hits on consecutive strips into a cluster and accumulates the total charge and the charge-weighted strip sum.

Closed clusters go to a single shared engine. A sequential divider in that engine produces a centroid with two fractional bits. Clusters from axial strips are then compared against the narrow windows of the track roads sent for the current event by an upstream, coarser track finder. A second table gives the window bounds for each road identifier. Clusters from stereo strips skip the comparison and leave the block directly.

An end-of-event pulse does three things: it closes every open cluster, it is passed on after the last result of the event, and it empties the road list.

Top module: `strip_cluster_matcher`

## Requirements
- R1: A hit whose strip is flagged dead in the strip table (data bit 16) is discarded, and it also does not bridge adjacency for the hits around it.
- R2: The corrected charge is `min(255, ((ph - ped) * gain) >> 6)`. Here `ped` is data bits 15:8 of the strip entry and `gain` is bits 7:0, with 64 meaning unity.
- R3: A hit is dropped when its pulse height is at or below the pedestal, or when its corrected charge comes out as zero.
- R4: A kept hit joins the open cluster of its input only if three conditions hold: its strip is exactly one above the previous strip, it has the same axial/stereo flag, and the cluster holds fewer than 8 strips. Otherwise the open cluster closes and the hit starts a new one.
- R5: A run of more than 8 consecutive strips is cut after every 8th strip.
- R6: The centroid is `floor(4 * sum(q*strip) / sum(q))`, which is the strip position in units of a quarter strip.
- R7: A hit flagged as frame-last closes the open cluster of its input after the hit is taken into account, whether the hit is kept or not.
- R8: An axial cluster produces one output for every stored road whose window matches. A window matches when its channel field equals the input index and `lo <= centroid <= hi`. The outputs come in ascending road slot order. An axial cluster with no match produces no output.
- R9: A stereo cluster produces exactly one output, with `out_axial` = 0 and `out_road` = 0.
- R10: Roads fill slots 0 to 15 in arrival order. Roads that arrive beyond 16 are ignored. The road list is cleared when `out_eoe` is issued.
- R11: `evt_end` closes every open cluster. `out_eoe` then pulses for one cycle, strictly after the last cluster output of the event, and never in the same cycle as `out_valid`.
- R12: The inputs cluster independently and in parallel. Outputs from one input keep the order in which that input's clusters closed.
- R13: With `tbl_win` = 0, a write goes to the strip table at address `{input, strip}`. With `tbl_win` = 1, a write goes to the window table at the road identifier, with data laid out as `{ch[20:18], lo[17:9], hi[8:0]}`.
- R14: During and right after reset, `out_valid` and `out_eoe` are low and every `hit_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_valid | input | NCH | Hit offered, one bit per input |
| hit_ready | output | NCH | Input can take a hit |
| hit_strip | input | NCH*SW | Strip address per input |
| hit_ph | input | NCH*PW | Raw pulse height per input |
| hit_axial | input | NCH | 1 = axial strip, 0 = stereo |
| hit_last | input | NCH | Hit ends its input frame |
| evt_end | input | 1 | End-of-event pulse; only given with no hit offered |
| road_valid | input | 1 | A road identifier is present |
| road_id | input | RIDW | Road identifier, used as the window table index |
| tbl_we | input | 1 | Table write strobe |
| tbl_win | input | 1 | 0 = strip table, 1 = window table |
| tbl_addr | input | TAW | Table address |
| tbl_data | input | TDW | Table write data |
| out_valid | output | 1 | Cluster result valid |
| out_ch | output | CHW | Input index of the cluster |
| out_axial | output | 1 | Axial flag of the cluster |
| out_road | output | RIW | Matched road slot |
| out_centroid | output | CW | Centroid in quarter strips |
| out_eoe | output | 1 | Forwarded end of event |

## Verification
After a cluster is closed, its pending slot must first win arbitration. The divider then needs NW (20) cycles. A stereo result appears on the cycle after the divider finishes. An axial cluster spends a further 16 cycles, one per road slot, with a registered output for each matching slot. Because the wait for arbitration depends on the other inputs, the bench does not check at fixed cycles. It models every hit as the block accepts it, files the expected results in a queue per input, and checks each `out_valid` against the head of the queue for that input, on the falling edge. At each `out_eoe` it checks that every queue is empty, which confirms the end marker comes after all results of the event.

// File: rtl/strip_cluster_matcher.sv
module strip_cluster_matcher #(
  parameter int NCH   = 8,
  parameter int SW    = 7,
  parameter int PW    = 8,
  parameter int MAXC  = 8,
  parameter int NROAD = 16,
  parameter int RIDW  = 6,
  parameter int GSH   = 6,
  parameter int CHW   = $clog2(NCH),
  parameter int CW    = SW + 2,
  parameter int RIW   = $clog2(NROAD),
  parameter int TAW   = CHW + SW,
  parameter int TDW   = CHW + 2*CW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    hit_valid,
  output logic [NCH-1:0]    hit_ready,
  input  logic [NCH*SW-1:0] hit_strip,
  input  logic [NCH*PW-1:0] hit_ph,
  input  logic [NCH-1:0]    hit_axial,
  input  logic [NCH-1:0]    hit_last,
  input  logic              evt_end,
  input  logic              road_valid,
  input  logic [RIDW-1:0]   road_id,
  input  logic              tbl_we,
  input  logic              tbl_win,
  input  logic [TAW-1:0]    tbl_addr,
  input  logic [TDW-1:0]    tbl_data,
  output logic              out_valid,
  output logic [CHW-1:0]    out_ch,
  output logic              out_axial,
  output logic [RIW-1:0]    out_road,
  output logic [CW-1:0]     out_centroid,
  output logic              out_eoe
);
  localparam int QW  = PW + 3;
  localparam int XW  = QW + SW;
  localparam int NW  = XW + 2;
  localparam int RW  = QW + 1;
  localparam int NCW = $clog2(MAXC + 1);
  localparam int DCW = $clog2(NW + 1);
  localparam int RCW = $clog2(NROAD + 1);
  localparam int EW  = 2*PW + 1;

  typedef enum logic [1:0] {E_IDLE, E_DIV, E_MATCH} est_t;

  logic [EW-1:0]   strip_tbl [NCH*(1<<SW)];
  logic [TDW-1:0]  win_tbl   [1<<RIDW];
  logic [RIDW-1:0] rid       [NROAD];
  logic [RCW-1:0]  rcnt;

  logic [NCH-1:0] pend_v, pend_ax, chan_busy, gnt;
  logic [QW-1:0]  pend_q [NCH];
  logic [XW-1:0]  pend_x [NCH];

  est_t           st;
  logic           eoe_pend, eax, gany;
  logic [CHW-1:0] ech, gsel;
  logic [QW-1:0]  den;
  logic [NW-1:0]  num, quo;
  logic [RW-1:0]  rem;
  logic [DCW-1:0] dcnt;
  logic [CW-1:0]  cent;
  logic [RIW-1:0] ridx;

  always_ff @(posedge clk)
    if (tbl_we) begin
      if (tbl_win) win_tbl[tbl_addr[RIDW-1:0]] <= tbl_data;
      else         strip_tbl[tbl_addr]         <= tbl_data[EW-1:0];
    end

  always_ff @(posedge clk)
    if (road_valid && rcnt < RCW'(NROAD)) rid[rcnt[RIW-1:0]] <= road_id;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam logic [CHW-1:0] GC = CHW'(g);
    logic            open, fin, pvl, axl, pax;
    logic [SW-1:0]   last;
    logic [NCW-1:0]  n;
    logic [QW-1:0]   sq, psq;
    logic [XW-1:0]   sx, psx;
    logic [2*PW-1:0] prod, scaled;
    logic [PW-1:0]   q;

    wire [SW-1:0] s    = hit_strip[g*SW +: SW];
    wire [PW-1:0] ph   = hit_ph[g*PW +: PW];
    wire [EW-1:0] ent  = strip_tbl[{GC, s}];
    wire [PW:0]   diff = {1'b0, ph} - {1'b0, ent[2*PW-1:PW]};
    assign prod   = {{PW{1'b0}}, diff[PW-1:0]} * {{PW{1'b0}}, ent[PW-1:0]};
    assign scaled = prod >> GSH;
    assign q      = (|scaled[2*PW-1:PW]) ? {PW{1'b1}} : scaled[PW-1:0];

    wire keep = !ent[2*PW] && !diff[PW] && (q != '0);
    wire take = hit_valid[g] && hit_ready[g];
    wire adj  = open && ((SW+1)'(s) == (SW+1)'(last) + (SW+1)'(1))
                && (n < NCW'(MAXC)) && (hit_axial[g] == axl);
    wire [XW-1:0] qs = XW'(q) * XW'(s);

    assign hit_ready[g] = !fin && !pvl;
    assign pend_v[g]    = pvl;
    assign pend_ax[g]   = pax;
    assign pend_q[g]    = psq;
    assign pend_x[g]    = psx;
    assign chan_busy[g] = open || pvl;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        open <= 1'b0; fin <= 1'b0; pvl <= 1'b0;
      end else begin
        if (gnt[g]) pvl <= 1'b0;
        if (take && keep) begin
          if (adj) begin
            n <= n + NCW'(1); sq <= sq + QW'(q); sx <= sx + qs;
          end else begin
            if (open) begin pvl <= 1'b1; psq <= sq; psx <= sx; pax <= axl; end
            open <= 1'b1; n <= NCW'(1); sq <= QW'(q); sx <= qs; axl <= hit_axial[g];
          end
          last <= s;
          fin  <= hit_last[g];
        end else if ((take && hit_last[g]) || evt_end) begin
          if (open) fin <= 1'b1;
        end else if (fin && !pvl) begin
          pvl <= 1'b1; psq <= sq; psx <= sx; pax <= axl; open <= 1'b0; fin <= 1'b0;
        end
      end
  end

  always_comb begin
    gsel = '0;
    gany = 1'b0;
    for (int i = NCH-1; i >= 0; i--)
      if (pend_v[i]) begin gsel = CHW'(i); gany = 1'b1; end
  end
  assign gnt = (st == E_IDLE && gany) ? (NCH'(1) << gsel) : '0;

  wire [RW-1:0]   rsh   = {rem[RW-2:0], num[NW-1]};
  wire            ge    = rsh >= {1'b0, den};
  wire [RW-1:0]   rnext = ge ? rsh - {1'b0, den} : rsh;
  wire [NW-1:0]   qnext = {quo[NW-2:0], ge};
  wire [TDW-1:0]  win   = win_tbl[rid[ridx]];
  wire            mhit  = (RCW'(ridx) < rcnt) && (win[TDW-1 -: CHW] == ech)
                          && (cent >= win[2*CW-1 -: CW]) && (cent <= win[CW-1:0]);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= E_IDLE; eoe_pend <= 1'b0; rcnt <= '0;
      out_valid <= 1'b0; out_eoe <= 1'b0; out_ch <= '0;
      out_axial <= 1'b0; out_road <= '0; out_centroid <= '0;
    end else begin
      out_valid <= 1'b0;
      out_eoe   <= 1'b0;
      if (evt_end) eoe_pend <= 1'b1;
      if (road_valid && rcnt < RCW'(NROAD)) rcnt <= rcnt + RCW'(1);
      case (st)
        E_IDLE:
          if (gany) begin
            st <= E_DIV; ech <= gsel; eax <= pend_ax[gsel];
            den <= pend_q[gsel]; num <= {pend_x[gsel], 2'b00};
            rem <= '0; quo <= '0; dcnt <= DCW'(NW);
          end else if (eoe_pend && !evt_end && chan_busy == '0) begin
            out_eoe <= 1'b1; eoe_pend <= 1'b0; rcnt <= '0;
          end
        E_DIV: begin
          rem <= rnext; num <= num << 1; quo <= qnext; dcnt <= dcnt - DCW'(1);
          if (dcnt == DCW'(1)) begin
            cent <= qnext[CW-1:0];
            ridx <= '0;
            if (eax) st <= E_MATCH;
            else begin
              st <= E_IDLE; out_valid <= 1'b1; out_axial <= 1'b0; out_road <= '0;
              out_ch <= ech; out_centroid <= qnext[CW-1:0];
            end
          end
        end
        default: begin
          out_valid <= mhit; out_axial <= 1'b1; out_road <= ridx;
          out_ch <= ech; out_centroid <= cent;
          if (ridx == RIW'(NROAD-1)) st <= E_IDLE;
          else ridx <= ridx + RIW'(1);
        end
      endcase
    end
endmodule

// File: rtl/strip_cluster_matcher_chk.sv
module strip_cluster_matcher_chk #(
  parameter int RIW = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           out_valid,
  input logic           out_eoe,
  input logic           out_axial,
  input logic [RIW-1:0] out_road
);
  assert_eoe_alone_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && out_eoe));
  assert_eoe_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_eoe |=> !out_eoe);
  assert_quiet_after_eoe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_eoe |=> !out_valid);
  assert_stereo_slot_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_axial) |-> (out_road == '0));
endmodule

bind strip_cluster_matcher strip_cluster_matcher_chk #(.RIW(RIW)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_eoe(out_eoe),
  .out_axial(out_axial), .out_road(out_road));

// File: tb/test_strip_cluster_matcher.sv
`timescale 1ns/1ps
module test_strip_cluster_matcher;
  localparam int NCH = 8, SW = 7, PW = 8, CHW = 3, CW = 9, RIW = 4, RIDW = 6;
  localparam int TAW = 10, TDW = 21;

  logic clk = 0, rst_n = 0;
  logic [NCH-1:0] hv = '0, hax = '0, hl = '0, hr;
  logic [NCH*SW-1:0] hs = '0;
  logic [NCH*PW-1:0] hp = '0;
  logic evt_end = 0, road_valid = 0, tbl_we = 0, tbl_win = 0;
  logic [RIDW-1:0] road_id = '0;
  logic [TAW-1:0] tbl_addr = '0;
  logic [TDW-1:0] tbl_data = '0;
  logic out_valid, out_axial, out_eoe;
  logic [CHW-1:0] out_ch;
  logic [RIW-1:0] out_road;
  logic [CW-1:0] out_centroid;

  always #10 clk = ~clk;

  strip_cluster_matcher i_strip_cluster_matcher (
    .clk(clk), .rst_n(rst_n), .hit_valid(hv), .hit_ready(hr), .hit_strip(hs),
    .hit_ph(hp), .hit_axial(hax), .hit_last(hl), .evt_end(evt_end),
    .road_valid(road_valid), .road_id(road_id), .tbl_we(tbl_we), .tbl_win(tbl_win),
    .tbl_addr(tbl_addr), .tbl_data(tbl_data), .out_valid(out_valid), .out_ch(out_ch),
    .out_axial(out_axial), .out_road(out_road), .out_centroid(out_centroid),
    .out_eoe(out_eoe));

  int checks = 0, errors = 0;
  string cur_req = "R14";
  bit done = 0, eoe_seen = 0;

  int bbad[1024], bped[1024], bgn[1024];
  int wch[64], wlo[64], whi[64];
  int rids[$];
  int mopen[NCH], mlast[NCH], mn[NCH], msq[NCH], msx[NCH], max_[NCH];
  int expq[NCH][$];

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Scoreboard monitor: R6 R8 R9 R12 order, R11 end marker
  always @(negedge clk) if (rst_n && !done) begin
    if (out_valid) begin
      int got;
      got = int'({out_ch, out_axial, out_road, out_centroid});
      if (expq[out_ch].size() == 0) check(0, {cur_req, " unexpected"}, got, -1);
      else begin
        int e;
        e = expq[out_ch].pop_front();
        check(got == e, cur_req, got, e);
      end
    end
    if (out_eoe) begin
      int left = 0;
      for (int c = 0; c < NCH; c++) left += expq[c].size();
      check(left == 0, "R11 pending at eoe", left, 0);
      eoe_seen = 1;
    end
  end

  task automatic wr(input bit w, input int a, input int d);
    @(negedge clk);
    tbl_we = 1; tbl_win = w; tbl_addr = TAW'(a); tbl_data = TDW'(d);
  endtask

  task automatic set_strip(input int c, input int s, input int bad, input int ped, input int g);
    int a = c*128 + s;
    bbad[a] = bad; bped[a] = ped; bgn[a] = g;
    wr(0, a, (bad << 16) | (ped << 8) | g);
  endtask

  task automatic set_win(input int id, input int c, input int lo, input int hi);
    wch[id] = c; wlo[id] = lo; whi[id] = hi;
    wr(1, id, (c << 18) | (lo << 9) | hi);
  endtask

  task automatic road(input int id);
    @(negedge clk);
    road_valid = 1; road_id = RIDW'(id);
    if (rids.size() < 16) rids.push_back(id);
    @(negedge clk);
    road_valid = 0;
  endtask

  function automatic void model_close(input int c);
    int cent;
    if (!mopen[c]) return;
    mopen[c] = 0;
    cent = (4*msx[c]) / msq[c];
    if (max_[c]) begin
      for (int r = 0; r < rids.size(); r++)
        if (wch[rids[r]] == c && cent >= wlo[rids[r]] && cent <= whi[rids[r]])
          expq[c].push_back((c << 14) | (1 << 13) | (r << 9) | cent);
    end else expq[c].push_back((c << 14) | cent);
  endfunction

  function automatic void model_hit(input int c, input int s, input int p, input int ax, input int lst);
    int a = c*128 + s, d, v;
    bit keep;
    d = p - bped[a];
    v = (d > 0) ? ((d * bgn[a]) >> 6) : 0;
    if (v > 255) v = 255;
    keep = !bbad[a] && d > 0 && v > 0;
    if (keep) begin
      if (mopen[c] && s == mlast[c] + 1 && mn[c] < 8 && ax == max_[c]) begin
        mn[c]++; msq[c] += v; msx[c] += v*s;
      end else begin
        model_close(c);
        mopen[c] = 1; mn[c] = 1; msq[c] = v; msx[c] = v*s; max_[c] = ax;
      end
      mlast[c] = s;
    end
    if (lst) model_close(c);
  endfunction

  task automatic hit(input int c, input int s, input int p, input int ax, input int lst);
    @(negedge clk);
    hv[c] = 1; hs[c*SW +: SW] = SW'(s); hp[c*PW +: PW] = PW'(p);
    hax[c] = ax[0]; hl[c] = lst[0];
    while (!hr[c]) @(negedge clk);
    model_hit(c, s, p, ax, lst);
    @(posedge clk); #1;
    hv[c] = 0;
  endtask

  task automatic end_event();
    int t = 0;
    @(negedge clk);
    evt_end = 1;
    for (int c = 0; c < NCH; c++) model_close(c);
    eoe_seen = 0;
    @(negedge clk);
    evt_end = 0;
    while (!eoe_seen && t < 5000) begin @(negedge clk); t++; end
    check(eoe_seen, "R11 eoe timeout", int'(eoe_seen), 1);
    rids.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NCH; c++) mopen[c] = 0;
    repeat (3) @(negedge clk);
    // R14 reset state
    check(out_valid == 0, "R14 out_valid", int'(out_valid), 0);
    check(out_eoe == 0, "R14 out_eoe", int'(out_eoe), 0);
    check(hr == '1, "R14 hit_ready", int'(hr), 255);
    rst_n = 1;
    @(negedge clk);
    check(hr == '1, "R14 hit_ready after", int'(hr), 255);

    // R13 table loading
    for (int c = 0; c < NCH; c++)
      for (int s = 0; s < 128; s++) set_strip(c, s, 0, 10, 64);
    set_strip(0, 20, 1, 10, 64);
    set_strip(0, 40, 0, 10, 128);
    set_strip(0, 41, 0, 10, 128);
    set_strip(2, 60, 0, 10, 1);
    for (int i = 0; i < 64; i++) set_win(i, 7, 1, 0);
    set_win(5, 0, 32, 56);
    set_win(9, 0, 40, 300);
    set_win(12, 1, 0, 511);
    set_win(3, 2, 0, 511);
    @(negedge clk); tbl_we = 0;

    // R1 R3 R4 R6 R7 R8 R13: adjacency, dead strip, low pulse, two-window match
    cur_req = "R1 R3 R4 R6 R7 R8";
    road(5); road(9); road(12);
    hit(0, 10, 60, 1, 0); hit(0, 11, 90, 1, 0); hit(0, 12, 30, 1, 0);
    hit(0, 15, 60, 1, 0);
    hit(0, 20, 200, 1, 0);
    hit(0, 21, 70, 1, 0); hit(0, 22, 8, 1, 0);
    hit(0, 23, 70, 1, 1);
    end_event();

    // R2 saturation, R5 split at 8, R4 orientation change, R9 stereo
    cur_req = "R2 R5 R4 R9";
    road(9);
    for (int s = 60; s < 70; s++) hit(0, s, 40, 1, 0);
    hit(0, 40, 255, 1, 0); hit(0, 41, 40, 1, 1);
    hit(0, 100, 50, 1, 0); hit(0, 101, 50, 0, 1);
    end_event();

    // R10 overflow and R12 parallel inputs
    cur_req = "R10 R12";
    for (int i = 0; i < 18; i++) road(12);
    fork
      begin hit(1, 5, 40, 1, 0); hit(1, 6, 40, 1, 1); end
      begin hit(2, 30, 50, 1, 1); end
      begin hit(3, 7, 90, 0, 0); hit(3, 8, 30, 0, 0); hit(3, 9, 70, 0, 1); end
      begin hit(0, 2, 50, 1, 1); end
    join
    end_event();

    // R10 cleared road list, R3 zero after gain, R11 flush of open cluster
    cur_req = "R10 R3 R11";
    hit(1, 5, 40, 1, 1);
    hit(1, 50, 30, 0, 0);
    hit(2, 60, 20, 0, 0); hit(2, 61, 40, 0, 0);
    end_event();

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule